// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Triggers

This block is a 32-pin general-purpose I/O port that is controlled through a small register bank. The bus is a 32-bit single-cycle read/write interface. Software writes an output value register and a direction register. The direction register drives each pin's output enable. A read-only register returns the pad inputs after they have been synchronized into the clock domain.

Each pin also acts as an interrupt source. Every pin has a 2-bit trigger code that selects low level, high level, rising edge or falling edge. A separate per-pin override makes a pin fire on both edges. Detected events set bits in a sticky pending register, and software clears those bits by writing ones. A mask register gates the pending bits onto two request lines: one for pins 0 to 15 and one for pins 16 to 31.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset the output value, direction, both trigger-config words, mask and both-edge registers read as zero, and `pad_oe` and `irq` are zero.
- R2: A write at offset 0x00 (output value) or 0x04 (direction) is read back unchanged. `pad_out` always equals the output value register. `pad_oe` equals the direction register, where bit n set to 1 makes pin n an output.
- R3: A read at offset 0x08 returns `pad_in` as it was two clock edges earlier, after the two-stage synchronizer.
- R4: Pin n takes its trigger code from bits [2(n mod 16)+1 : 2(n mod 16)] of the register at offset 0x0C for pins 0–15, or at offset 0x10 for pins 16–31. The codes are: 0 = synchronized input low, 1 = synchronized input high, 2 = 0→1 transition, 3 = 1→0 transition. The pending bit is visible one edge after the condition appears on the synchronized input.
- R5: When bit n of the register at offset 0x1C is 1, pin n sets its pending bit on every transition of its synchronized input, and its trigger code is ignored.
- R6: The pending register at offset 0x18 is sticky. A bus write to it clears exactly the bits written as 1 and leaves every other bit unchanged.
- R7: An edge event that coincides with a clear of its bit still leaves the bit set. A level-triggered bit that is cleared while its level still holds reads 0 for one cycle and then sets again.
- R8: Pending bits are set whatever the mask (offset 0x14) holds. `irq[0]` is the OR of pending AND mask over pins 0–15, and `irq[1]` is the same OR over pins 16–31.
- R9: A write to the pad status offset changes no register, and a write of 0 to the pending register clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset; bits [1:0] are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not selected |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Pad output levels |
| pad_oe | output | 32 | Pad output enables |
| irq | output | 2 | Interrupt requests, lower and upper pin halves |

## Verification
The assertions assume that `bus_wr` only matters while `bus_sel` is high and that `pad_in` changes well away from the clock edge. The stimulus changes every input only at the falling edge, which keeps it within both assumptions. Random traffic uses word offsets only. It mixes writes that leave pending bits alone with occasional clears, and it holds the pad values for several cycles at a time so that edge and level events both occur while the mask is partly open.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int unsigned PINS = 32;
    localparam int unsigned HALF = PINS / 2;

    typedef enum logic [2:0] {
        SEL_DATA  = 3'd0,
        SEL_DIR   = 3'd1,
        SEL_PAD   = 3'd2,
        SEL_CFGLO = 3'd3,
        SEL_CFGHI = 3'd4,
        SEL_MASK  = 3'd5,
        SEL_PEND  = 3'd6,
        SEL_BOTH  = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'd0,
        TRIG_HIGH = 2'd1,
        TRIG_RISE = 2'd2,
        TRIG_FALL = 2'd3
    } trig_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < int'(STAGES); i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= '0;
        end else begin
            for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= stg_d[i];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_trig.sv
module gpio_trig
    import gpio_irq_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0]   cur,
    input  logic [W-1:0]   prev,
    input  logic [2*W-1:0] codes,
    input  logic [W-1:0]   both,
    output logic [W-1:0]   edge_hit,
    output logic [W-1:0]   level_hit
);
    for (genvar p = 0; p < int'(W); p++) begin : g_pin
        trig_e mode;
        assign mode = trig_e'(codes[2*p +: 2]);
        always_comb begin
            edge_hit[p]  = 1'b0;
            level_hit[p] = 1'b0;
            if (both[p]) begin
                edge_hit[p] = cur[p] ^ prev[p];
            end else begin
                unique case (mode)
                    TRIG_LOW:  level_hit[p] = ~cur[p];
                    TRIG_HIGH: level_hit[p] = cur[p];
                    TRIG_RISE: edge_hit[p]  = cur[p] & ~prev[p];
                    TRIG_FALL: edge_hit[p]  = ~cur[p] & prev[p];
                    default:   edge_hit[p]  = 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [4:0]      bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    input  logic [PINS-1:0] pad_in,
    output logic [PINS-1:0] pad_out,
    output logic [PINS-1:0] pad_oe,
    output logic [1:0]      irq
);
    typedef struct packed {
        logic [PINS-1:0] data;
        logic [PINS-1:0] dir;
        logic [PINS-1:0] cfglo;
        logic [PINS-1:0] cfghi;
        logic [PINS-1:0] mask;
        logic [PINS-1:0] pend;
        logic [PINS-1:0] both;
        logic [PINS-1:0] prev;
    } state_t;

    state_t          st_d, st_q;
    logic [PINS-1:0] sync_in;
    logic [PINS-1:0] edge_hit, level_hit;
    logic [PINS-1:0] clr;
    logic [PINS-1:0] mask_view, pend_view;
    reg_sel_e        sel;

    gpio_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (sync_in)
    );

    gpio_trig #(.W(PINS)) u_trig (
        .cur       (sync_in),
        .prev      (st_q.prev),
        .codes     ({st_q.cfghi, st_q.cfglo}),
        .both      (st_q.both),
        .edge_hit  (edge_hit),
        .level_hit (level_hit)
    );

    assign sel = reg_sel_e'(bus_addr[4:2]);
    assign clr = (bus_sel && bus_wr && sel == SEL_PEND) ? bus_wdata : '0;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sync_in;
        st_d.pend = (st_q.pend & ~clr) | edge_hit | (level_hit & ~clr);
        if (bus_sel && bus_wr) begin
            unique case (sel)
                SEL_DATA:  st_d.data  = bus_wdata;
                SEL_DIR:   st_d.dir   = bus_wdata;
                SEL_CFGLO: st_d.cfglo = bus_wdata;
                SEL_CFGHI: st_d.cfghi = bus_wdata;
                SEL_MASK:  st_d.mask  = bus_wdata;
                SEL_BOTH:  st_d.both  = bus_wdata;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (sel)
                SEL_DATA:  bus_rdata = st_q.data;
                SEL_DIR:   bus_rdata = st_q.dir;
                SEL_PAD:   bus_rdata = sync_in;
                SEL_CFGLO: bus_rdata = st_q.cfglo;
                SEL_CFGHI: bus_rdata = st_q.cfghi;
                SEL_MASK:  bus_rdata = st_q.mask;
                SEL_PEND:  bus_rdata = st_q.pend;
                SEL_BOTH:  bus_rdata = st_q.both;
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign pad_out   = st_q.data;
    assign pad_oe    = st_q.dir;
    assign mask_view = st_q.mask;
    assign pend_view = st_q.pend;
    assign irq[0]    = |(st_q.pend[HALF-1:0] & st_q.mask[HALF-1:0]);
    assign irq[1]    = |(st_q.pend[PINS-1:HALF] & st_q.mask[PINS-1:HALF]);
endmodule

module gpio_irq_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [4:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] pad_out,
    input logic [31:0] pad_oe,
    input logic [31:0] mask_view,
    input logic [31:0] pend_view,
    input logic [1:0]  irq
);
    // R6
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr && bus_addr[4:2] == 3'd6)
        |=> ((pend_view & $past(pend_view)) == $past(pend_view)));

    // R2
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr[4:2] == 3'd1) |=> pad_oe == $past(bus_wdata));

    // R2
    data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr[4:2] == 3'd0) |=> pad_out == $past(bus_wdata));

    // R8
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_view == 32'd0) |-> irq == 2'b00);

    // R9
    pad_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr[4:2] == 3'd2)
        |=> ($stable(pad_out) && $stable(pad_oe) && $stable(mask_view)));
endmodule

bind gpio_irq_port gpio_irq_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .mask_view (mask_view),
    .pend_view (pend_view),
    .irq       (irq)
);

// File: tb/sim_gpio_irq_port.sv
module sim_gpio_irq_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [31:0] pad_in = '0, pad_out, pad_oe;
    logic [1:0]  irq;

    int errors = 0, checks = 0;
    bit done = 0;

    // reference state
    logic [31:0] m_data = 0, m_dir = 0, m_lo = 0, m_hi = 0, m_mask = 0;
    logic [31:0] m_pend = 0, m_both = 0, m_s1 = 0, m_s2 = 0, m_prev = 0;

    always #5 clk = ~clk;

    gpio_irq_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    function automatic logic [31:0] model_read(input logic [2:0] idx);
        case (idx)
            3'd0: return m_data;
            3'd1: return m_dir;
            3'd2: return m_s2;
            3'd3: return m_lo;
            3'd4: return m_hi;
            3'd5: return m_mask;
            3'd6: return m_pend;
            default: return m_both;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] idx);
        case (idx)
            3'd0, 3'd1: return "R2";
            3'd2:       return "R3";
            3'd3, 3'd4: return "R4";
            3'd5:       return "R8";
            3'd6:       return "R6";
            default:    return "R5";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock cycle: drive at falling edge, compare, advance model, wait for rising edge
    task automatic cyc(input bit sel, input bit wr, input logic [2:0] idx,
                       input logic [31:0] wd, input logic [31:0] pad, input string rtag);
        logic [31:0] eh, lh, clr;
        logic [1:0]  code;
        @(negedge clk);
        bus_sel = sel; bus_wr = wr; bus_addr = {idx, 2'b00}; bus_wdata = wd; pad_in = pad;
        #1;
        if (sel && !wr) check(rtag == "" ? tag_of(idx) : rtag, bus_rdata, model_read(idx));
        check("R2 pad_out", pad_out, m_data);
        check("R2 pad_oe", pad_oe, m_dir);
        check("R8 irq", {30'd0, irq},
              {30'd0, |(m_pend[31:16] & m_mask[31:16]), |(m_pend[15:0] & m_mask[15:0])});
        eh = 0; lh = 0;
        for (int p = 0; p < 32; p++) begin
            code = (p < 16) ? m_lo[2*p +: 2] : m_hi[2*(p-16) +: 2];
            if (m_both[p]) eh[p] = m_s2[p] ^ m_prev[p];
            else case (code)
                2'd0: lh[p] = !m_s2[p];
                2'd1: lh[p] = m_s2[p];
                2'd2: eh[p] = m_s2[p] && !m_prev[p];
                default: eh[p] = !m_s2[p] && m_prev[p];
            endcase
        end
        clr = (sel && wr && idx == 3'd6) ? wd : 32'd0;
        m_pend = (m_pend & ~clr) | eh | (lh & ~clr);
        m_prev = m_s2; m_s2 = m_s1; m_s1 = pad;
        if (sel && wr) case (idx)
            3'd0: m_data = wd;
            3'd1: m_dir  = wd;
            3'd3: m_lo   = wd;
            3'd4: m_hi   = wd;
            3'd5: m_mask = wd;
            3'd7: m_both = wd;
            default: ;
        endcase
        @(posedge clk);
    endtask

    task automatic wr_reg(input logic [2:0] idx, input logic [31:0] wd);
        cyc(1, 1, idx, wd, pad_in, "");
    endtask
    task automatic rd_reg(input logic [2:0] idx, input string t);
        cyc(1, 0, idx, 0, pad_in, t);
    endtask
    task automatic idle(input logic [31:0] pad, input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, pad, "");
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] pad;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        check("R1 irq", {30'd0, irq}, 32'd0);
        check("R1 pad_oe", pad_oe, 32'd0);
        for (int r = 0; r < 8; r++) rd_reg(3'(r), "R1");

        // R2 readback and output drive
        wr_reg(3'd0, 32'hA5C3_0F81); wr_reg(3'd1, 32'h0FF0_F00F);
        rd_reg(3'd0, "R2"); rd_reg(3'd1, "R2");

        // R9 writes with no effect
        wr_reg(3'd2, 32'hFFFF_FFFF); rd_reg(3'd0, "R9"); rd_reg(3'd5, "R9");
        wr_reg(3'd6, 32'h0); rd_reg(3'd6, "R9");

        // R3 synchronized pad read
        cyc(0, 0, 0, 0, 32'h1234_5678, ""); rd_reg(3'd2, "R3"); rd_reg(3'd2, "R3");

        // R4 rise low half, fall high half
        idle(32'h0000_0000, 3);
        wr_reg(3'd3, 32'hAAAA_AAAA); wr_reg(3'd4, 32'hFFFF_FFFF);
        wr_reg(3'd5, 32'hFFFF_FFFF); wr_reg(3'd6, 32'hFFFF_FFFF);
        rd_reg(3'd6, "R4");
        idle(32'h0010_0008, 4); rd_reg(3'd6, "R4");
        idle(32'h0000_0008, 4); rd_reg(3'd6, "R4");
        wr_reg(3'd6, 32'hFFFF_FFFF); idle(32'h0000_0000, 4); rd_reg(3'd6, "R4");

        // R5 both-edge override on pin 5
        wr_reg(3'd6, 32'hFFFF_FFFF); wr_reg(3'd7, 32'h0000_0020);
        idle(32'h0000_0020, 4); rd_reg(3'd6, "R5");
        wr_reg(3'd6, 32'h0000_0020); idle(32'h0000_0000, 4); rd_reg(3'd6, "R5");

        // R7 level re-set after clear on pin 7 (high level)
        wr_reg(3'd7, 32'h0); wr_reg(3'd3, 32'hAAAA_6AAA);
        idle(32'h0000_0080, 4);
        wr_reg(3'd6, 32'hFFFF_FFFF); rd_reg(3'd6, "R7"); rd_reg(3'd6, "R7");

        // R7 edge coincident with clear on pin 3 (rising)
        wr_reg(3'd6, 32'hFFFF_FFFF); idle(32'h0000_0080, 2);
        cyc(0, 0, 0, 0, 32'h0000_0088, "");
        idle(32'h0000_0088, 1);
        cyc(1, 1, 3'd6, 32'h0000_0008, 32'h0000_0088, "");
        rd_reg(3'd6, "R7");

        // R8 half-masked pending
        wr_reg(3'd5, 32'h0000_FFFF); rd_reg(3'd6, "R8"); rd_reg(3'd5, "R8");

        // random traffic
        pad = $urandom;
        for (int i = 0; i < 4000; i++) begin
            logic [2:0]  idx;
            logic [31:0] wd;
            if ($urandom_range(0, 7) == 0) pad = pad ^ (32'h1 << $urandom_range(0, 31)) ^ ($urandom & $urandom & $urandom);
            idx = 3'($urandom_range(0, 7));
            wd  = $urandom;
            if (idx == 3'd6) wd = wd & $urandom & $urandom;
            case ($urandom_range(0, 3))
                0: cyc(1, 1, idx, wd, pad, "");
                1: cyc(1, 0, idx, 0, pad, "");
                default: cyc(0, 0, 0, 0, pad, "");
            endcase
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule